// File: doc/BRIEF.md
# Memory Command Rate Monitor

This block sits beside the command request path of a memory controller and only watches it. It splits time into fixed measurement windows of 2^WIN_LOG2 clock cycles, counted from the release of reset. It counts accepted read commands and accepted write commands in each window. When a window closes, both totals are latched into a snapshot layer. Software sees them only after it pulses an update strobe, which copies the latest completed snapshot into the status outputs. The configured memory data width is presented as a constant status value, so software can turn counts into bandwidth.

The command stream is valid/ready, but the monitor drives neither signal. Back-pressure belongs entirely to the producer and the consumer of that stream. A command counts in exactly the cycle where `cmd_valid` and `cmd_ready` are both high. Stalled cycles, with valid high and ready low, count nothing, however long the stall lasts. The strobe, the counts and the width value are plain level signals with no handshake.

Top module: `cmd_bw_monitor`

## Requirements
- R1: Windows are exactly 2^WIN_LOG2 cycles long. The first window starts in the first cycle after reset is released, and each later window starts in the cycle after the previous one ends.
- R2: A command counts only in a cycle where both `cmd_valid` and `cmd_ready` are high. Valid without ready, or ready without valid, adds nothing.
- R3: The type is taken from two flags. `cmd_is_read`=1 marks a read. `cmd_is_read`=0 with `cmd_is_write`=1 marks a write. Both flags low marks a non-data command (activate, precharge, refresh, idle), which is never counted.
- R4: Read and write totals are kept in separate counters and appear on separate outputs, `rd_count_o` and `wr_count_o`.
- R5: The status outputs change only on a clock edge where `update_stb` is high. After reset they stay at zero until the first update, no matter how many windows have closed.
- R6: An edge with `update_stb` high loads the status outputs with the totals of the most recently completed window, visible in the following cycle. If the strobe is held high, the outputs change once per window, exactly 2^WIN_LOG2 cycles apart.
- R7: A command accepted in the last cycle of a window belongs to that window and to no other. The per-window totals sum to the number of accepted commands.
- R8: A window in which a command of one type is accepted every cycle reports 2^WIN_LOG2 without wrapping. The count outputs are WIN_LOG2+1 bits wide.
- R9: `data_width_o` always equals the DATA_WIDTH parameter.
- R10: An update strobe in the last cycle of a window delivers the previously completed window's totals. The window closing in that cycle becomes visible only at a later update.
- R11: Synchronous reset clears the window timer, the running counts, the snapshots and the status outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command request valid, observed only |
| cmd_ready | input | 1 | Command request ready, observed only |
| cmd_is_read | input | 1 | Request is a read |
| cmd_is_write | input | 1 | Request is a write |
| update_stb | input | 1 | Copy the latest completed window into the status outputs |
| rd_count_o | output | WIN_LOG2+1 | Reads of the window last copied |
| wr_count_o | output | WIN_LOG2+1 | Writes of the window last copied |
| data_width_o | output | DW_STAT_W | Configured data width, constant |

## Verification
Two events can fall in the same cycle. A window can close in the cycle a command is accepted, and a window can close in the cycle software pulses the update strobe. The first case is provoked by a burst of writes that straddles a boundary. It is judged by reading the two neighbouring windows: the split must match the cycle positions and the two parts must add up to the burst length. The second case is provoked by strobing in the last cycle of a window and again one cycle later. The status must first show the older window and then the newer one, and a held strobe must produce changes exactly one window apart.

// File: rtl/bwmon_pkg.sv
package bwmon_pkg;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_RD    = 2'd1,
    CLS_WR    = 2'd2
  } cmd_cls_e;

  localparam int NUM_CH = 2;
  localparam int CH_RD  = 0;
  localparam int CH_WR  = 1;

  // Read flag wins over write flag; neither flag means a non-data command.
  function automatic cmd_cls_e classify(input logic is_rd, input logic is_wr);
    if (is_rd) return CLS_RD;
    if (is_wr) return CLS_WR;
    return CLS_OTHER;
  endfunction

endpackage

// File: rtl/bwmon_cmd_decode.sv
module bwmon_cmd_decode
  import bwmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              ready,
  input  logic              is_rd,
  input  logic              is_wr,
  output logic [NUM_CH-1:0] hit
);

  logic     fire;
  cmd_cls_e cls;

  assign fire = valid & ready;
  assign cls  = classify(is_rd, is_wr);

  always_comb begin
    hit        = '0;
    hit[CH_RD] = fire && (cls == CLS_RD);
    hit[CH_WR] = fire && (cls == CLS_WR);
  end

  // R3: at most one channel per accepted command
  a_r3_single_channel: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));

  // R2: nothing counts without a full handshake
  a_r2_needs_handshake: assert property (@(posedge clk) disable iff (rst)
    !(valid && ready) |-> (hit == '0));

endmodule

// File: rtl/bwmon_window_timer.sv
module bwmon_window_timer #(
  parameter int WIN_LOG2 = 5
) (
  input  logic clk,
  input  logic rst,
  output logic win_end
);

  logic [WIN_LOG2-1:0] tick;

  always_ff @(posedge clk) begin
    if (rst) tick <= '0;
    else     tick <= tick + 1'b1;
  end

  assign win_end = &tick;

  // R1: a closing cycle is never directly followed by another
  a_r1_single_end: assert property (@(posedge clk) disable iff (rst)
    win_end |=> !win_end);

endmodule

// File: rtl/bwmon_event_counter.sv
module bwmon_event_counter #(
  parameter int WIN_LOG2 = 5,
  localparam int CW = WIN_LOG2 + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          win_end,
  output logic [CW-1:0] snap
);

  localparam logic [CW-1:0] WIN_LEN = CW'(1) << WIN_LOG2;

  logic [CW-1:0] run;
  logic [CW-1:0] inc;

  assign inc = {{(CW-1){1'b0}}, hit};

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= '0;
      snap <= '0;
    end else if (win_end) begin
      snap <= run + inc;
      run  <= '0;
    end else begin
      run  <= run + inc;
    end
  end

  // R8: running total stays below one window, snapshot at most one window
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (run < WIN_LEN) && (snap <= WIN_LEN));

  // R7: snapshot moves only when a window closes
  a_r7_snap_on_end: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(snap));

  // R2: running total holds when nothing is accepted
  a_r2_run_hold: assert property (@(posedge clk) disable iff (rst)
    (!hit && !win_end) |=> $stable(run));

endmodule

// File: rtl/bwmon_status_regs.sv
module bwmon_status_regs
  import bwmon_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       upd,
  input  logic [NUM_CH-1:0][CW-1:0]  snap,
  output logic [NUM_CH-1:0][CW-1:0]  stat
);

  always_ff @(posedge clk) begin
    if (rst)      stat <= '0;
    else if (upd) stat <= snap;
  end

  // R5: status frozen without a strobe
  a_r5_hold_without_update: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(stat));

  // R6: a strobe delivers the snapshot seen at that edge
  a_r6_copy_snapshot: assert property (@(posedge clk) disable iff (rst)
    upd |=> (stat == $past(snap)));

endmodule

// File: rtl/cmd_bw_monitor.sv
module cmd_bw_monitor
  import bwmon_pkg::*;
#(
  parameter int WIN_LOG2   = 5,
  parameter int DATA_WIDTH = 64,
  parameter int DW_STAT_W  = 16,
  localparam int CW = WIN_LOG2 + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic                 cmd_ready,
  input  logic                 cmd_is_read,
  input  logic                 cmd_is_write,
  input  logic                 update_stb,
  output logic [CW-1:0]        rd_count_o,
  output logic [CW-1:0]        wr_count_o,
  output logic [DW_STAT_W-1:0] data_width_o
);

  logic                      win_end;
  logic [NUM_CH-1:0]         hit;
  logic [NUM_CH-1:0][CW-1:0] snap;
  logic [NUM_CH-1:0][CW-1:0] stat;

  bwmon_cmd_decode u_decode (
    .clk   (clk),
    .rst   (rst),
    .valid (cmd_valid),
    .ready (cmd_ready),
    .is_rd (cmd_is_read),
    .is_wr (cmd_is_write),
    .hit   (hit)
  );

  bwmon_window_timer #(.WIN_LOG2(WIN_LOG2)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .win_end (win_end)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    bwmon_event_counter #(.WIN_LOG2(WIN_LOG2)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .hit     (hit[ch]),
      .win_end (win_end),
      .snap    (snap[ch])
    );
  end

  bwmon_status_regs #(.CW(CW)) u_status (
    .clk  (clk),
    .rst  (rst),
    .upd  (update_stb),
    .snap (snap),
    .stat (stat)
  );

  assign rd_count_o   = stat[CH_RD];
  assign wr_count_o   = stat[CH_WR];
  assign data_width_o = DW_STAT_W'(DATA_WIDTH);

endmodule

// File: tb/tb_cmd_bw_monitor.sv
module tb_cmd_bw_monitor;

  localparam int WIN_LOG2 = 5;
  localparam int N        = 1 << WIN_LOG2;
  localparam int DW       = 64;
  localparam int CW       = WIN_LOG2 + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready = 1'b0;
  logic          cmd_is_read = 1'b0;
  logic          cmd_is_write = 1'b0;
  logic          update_stb = 1'b0;
  logic [CW-1:0] rd_count_o;
  logic [CW-1:0] wr_count_o;
  logic [15:0]   data_width_o;

  int checks = 0;
  int errors = 0;
  int k = 0;

  always #4 clk = ~clk;

  cmd_bw_monitor #(.WIN_LOG2(WIN_LOG2), .DATA_WIDTH(DW), .DW_STAT_W(16)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_is_read(cmd_is_read), .cmd_is_write(cmd_is_write),
    .update_stb(update_stb), .rd_count_o(rd_count_o),
    .wr_count_o(wr_count_o), .data_width_o(data_width_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle (index k) from the falling edge, return on the next falling edge.
  task automatic step(input logic v, input logic r, input logic rd,
                      input logic wr, input logic up);
    cmd_valid = v; cmd_ready = r; cmd_is_read = rd; cmd_is_write = wr;
    update_stb = up;
    @(posedge clk);
    @(negedge clk);
    k++;
  endtask

  task automatic idle(input logic up);
    step(1'b0, 1'b0, 1'b0, 1'b0, up);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    idle(1'b0);
    idle(1'b0);
    rst = 1'b0;
    k = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 rd after reset", int'(rd_count_o), 0);
    chk("R11 wr after reset", int'(wr_count_o), 0);
    chk("R9 data width", int'(data_width_o), DW);
  endtask

  task automatic t_no_update();
    int nrd;
    do_reset();
    nrd = 0;
    for (int i = 0; i < 3 * N; i++) begin
      step(1'b1, 1'b1, i[0] == 1'b0, 1'b0, 1'b0);
      if (i % N == N - 1) begin
        chk("R5 rd frozen", int'(rd_count_o), 0);
        chk("R5 wr frozen", int'(wr_count_o), 0);
      end
    end
    idle(1'b1);
    chk("R6 rd after late update", int'(rd_count_o), N / 2);
    chk("R6 wr after late update", int'(wr_count_o), 0);
  endtask

  task automatic t_mix();
    int nrd, nwr;
    do_reset();
    nrd = 0; nwr = 0;
    for (int i = 0; i < N; i++) begin
      case (i % 8)
        0: begin step(1, 1, 1, 0, 0); nrd++; end
        1: begin step(1, 1, 0, 1, 0); nwr++; end
        2: step(1, 0, 1, 0, 0);
        3: step(0, 1, 0, 1, 0);
        4: step(1, 1, 0, 0, 0);
        5: begin step(1, 1, 0, 1, 0); nwr++; end
        6: begin step(1, 1, 1, 0, 0); nrd++; end
        default: step(0, 1, 1, 0, 0);
      endcase
    end
    idle(1'b1);
    chk("R2 R4 read count", int'(rd_count_o), nrd);
    chk("R3 R4 write count", int'(wr_count_o), nwr);
    for (int i = 0; i < N - 1; i++) step(1, 1, 0, 0, 0);
    idle(1'b1);
    chk("R3 non-data reads ignored", int'(rd_count_o), 0);
    chk("R3 non-data writes ignored", int'(wr_count_o), 0);
  endtask

  task automatic t_boundary();
    int sum;
    do_reset();
    for (int i = 0; i < N + 10; i++)
      step(1'b1, 1'b1, 1'b0, (i >= N - 10), (i == N));
    chk("R7 first window share", int'(wr_count_o), 10);
    sum = int'(wr_count_o);
    while (k < 2 * N) idle(1'b0);
    idle(1'b1);
    chk("R7 second window share", int'(wr_count_o), 10);
    sum += int'(wr_count_o);
    chk("R7 sum equals accepted", sum, 20);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < N; i++) step(1, 1, 1, 0, 0);
    for (int i = 0; i < N; i++) step(1, 1, 0, 1, (i == 0));
    chk("R8 full read window", int'(rd_count_o), N);
    chk("R8 no writes in read window", int'(wr_count_o), 0);
    idle(1'b1);
    chk("R8 full write window", int'(wr_count_o), N);
    chk("R8 no reads in write window", int'(rd_count_o), 0);
  endtask

  task automatic t_continuous();
    int last_val, last_chg, nchg;
    logic w;
    do_reset();
    last_val = 0; last_chg = -1; nchg = 0;
    for (int i = 0; i < 3 * N + 1; i++) begin
      w = (i >= 10 && i < 13) || (i >= N + 10 && i < N + 16) ||
          (i >= 2 * N + 10 && i < 2 * N + 19);
      step(w, 1'b1, 1'b0, w, 1'b1);
      if (int'(wr_count_o) != last_val) begin
        nchg++;
        chk("R6 change cycle", k - 1, nchg * N);
        chk("R6 changed value", int'(wr_count_o), 3 * nchg);
        if (last_chg >= 0) chk("R1 change spacing", (k - 1) - last_chg, N);
        last_chg = k - 1;
        last_val = int'(wr_count_o);
      end
    end
    chk("R1 number of changes", nchg, 3);
  endtask

  task automatic t_coincide();
    do_reset();
    for (int i = 0; i < 2 * N + 1; i++) begin
      logic w;
      w = (i >= 3 && i < 8) || (i >= N + 8 && i < N + 15);
      step(w, 1'b1, 1'b0, w, (i == N - 1) || (i == 2 * N - 1) || (i == 2 * N));
      if (i == N - 1)     chk("R10 strobe at first close", int'(wr_count_o), 0);
      if (i == 2 * N - 1) chk("R10 strobe at second close", int'(wr_count_o), 5);
      if (i == 2 * N)     chk("R10 next cycle sees newer", int'(wr_count_o), 7);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_no_update();
    t_mix();
    t_boundary();
    t_full();
    t_continuous();
    t_coincide();
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule